// File: doc/BRIEF.md
# Four-Lane Multi-Sample FIR Engine

The engine produces four neighbouring outputs of an N-tap FIR filter, y(n), y(n+1), y(n+2) and y(n+3), in one pass. Four multiply-accumulate lanes run side by side. Lane j owns output y(n+j). The coefficient index k advances by one per step, so every lane adds its products in the same order that a single serial accumulator would use. Each lane's result therefore matches that serial computation bit for bit, including saturation.

The caller pulses `start` with a base index n and a tap count N. The engine then reads from two external memories that return data one cycle after the address. It first preloads the samples x(n+3) down to x(n). After that, each step fetches one coefficient and one older sample. The three remaining samples of a step are the ones used in the previous step, each moved up by one lane. When the pass ends, the four results are rounded to Q15 and saturated. They appear on `y_out` together with a one-cycle `done` pulse.

Top module: `msfir_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and `y_out` is zero. A `start` accepted while idle clears all lane accumulators, latches `base_n` and `taps`, and drives `busy` high from the next cycle until the pass completes.
- R2: A pass asserts `samp_rd` for exactly N+3 consecutive cycles. In those cycles `samp_addr` takes the values n+3, n+2, n+1, n, n-1, and so on down to n-N+1, one per cycle and modulo 2^AW.
- R3: `coef_rd` is asserted for exactly N cycles. Its first cycle coincides with the read of sample x(n). The coefficient addresses run 0, 1, ..., N-1, and every coefficient read is paired with a sample read in the same cycle, so each step after the preload moves two words.
- R4: Lane j, whose output sits in bits [16j+15:16j] of `y_out`, delivers y(n+j) computed from the terms a_k·x(n+j-k) summed in order k = 0..N-1. Samples and coefficients are 16-bit signed Q15, and each product is a full 32-bit signed value.
- R5: Each accumulation saturates to the signed range of a (32+GUARD)-bit accumulator, which is 40 bits by default. The result therefore depends on the order of the terms. For example, a large positive run that clips, followed by negative terms, ends below the unclipped sum.
- R6: Each output equals (acc + 2^14) arithmetically shifted right by 15, then saturated to [-32768, 32767]. This rounds a half up: an accumulator of 16384 gives 1, 16383 gives 0 and -16385 gives -1.
- R7: `done` rises exactly N+5 clock edges after the edge that accepts `start` and stays high for one cycle. `y_out` changes only at that edge and holds its value until the next `done`.
- R8: A `start` that arrives while `busy` is high has no effect. The running pass keeps its base, tap count, address sequence, timing and results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| base_n | input | AW | Base sample index n |
| taps | input | $clog2(MAX_TAPS+1) | Tap count N (1..MAX_TAPS) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse, results valid |
| samp_rd | output | 1 | Sample read strobe |
| samp_addr | output | AW | Sample read address |
| samp_data | input | 16 | Sample returned one cycle after the address |
| coef_rd | output | 1 | Coefficient read strobe |
| coef_addr | output | $clog2(MAX_TAPS) | Coefficient read address |
| coef_data | input | 16 | Coefficient returned one cycle after the address |
| y_out | output | 4×16 | Four rounded results, lane 0 in the low bits |

## Verification
A sample window that shifts the wrong way, or a slot that keeps a stale value, gives wrong results on the lanes that reuse that sample. A random-data pass shows this on the very next `done`, while lane 0, which always takes fresh data, stays correct. An accumulator that wraps instead of clipping, or that clips only at the end, is exposed only by the ordered-saturation passes. There it flips the sign or the magnitude of the rounded output in that same pass. A sequencer fault shows up as soon as the first misplaced read happens, through the address trace: a skipped step, an off-by-one preload, or a restart on a mid-pass `start`. It also moves `done` away from its N+5-edge position.

// File: rtl/msfir_pkg.sv
package msfir_pkg;

    localparam int SW        = 16;   // sample and coefficient width (Q15)
    localparam int PW        = 32;   // full product width
    localparam int RND_SHIFT = 15;   // Q30 -> Q15

    typedef logic signed [SW-1:0] smp_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_LAST,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic vld;   // read data arrives this cycle
        logic mac;   // arriving data belongs to a multiply step
    } ret_flags_t;

    // Clamp a wide signed value to a w-bit signed range.
    function automatic logic signed [63:0] clamp_w(input logic signed [63:0] v, input int w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        return v;
    endfunction

    // Round half up from Q30 accumulator scale to Q15 and saturate.
    function automatic smp_t round_q15(input logic signed [63:0] acc);
        logic signed [63:0] r;
        r = (acc + (64'sd1 <<< (RND_SHIFT - 1))) >>> RND_SHIFT;
        r = clamp_w(r, SW);
        return r[SW-1:0];
    endfunction

endpackage

// File: rtl/msfir_seq.sv
module msfir_seq
    import msfir_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 12,
    parameter int TW    = 7,
    parameter int IW    = 7,
    parameter int CAW   = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [AW-1:0]  base_n,
    input  logic [TW-1:0]  taps,
    output logic           busy,
    output logic           done,
    output logic           clr,
    output logic           fin,
    output logic           samp_rd,
    output logic [AW-1:0]  samp_addr,
    output logic           coef_rd,
    output logic [CAW-1:0] coef_addr,
    output ret_flags_t     ret
);

    localparam logic [IW-1:0] PRELOAD = IW'(LANES - 1);
    localparam logic [IW-1:0] TAIL    = IW'(LANES - 2);

    seq_state_e    state;
    logic [IW-1:0] idx;
    logic [AW-1:0] base_q;
    logic [TW-1:0] ntap_q;

    logic issuing;
    logic pre_done;
    logic last_issue;

    assign issuing    = (state == ST_ISSUE);
    assign pre_done   = (idx >= PRELOAD);
    assign last_issue = (idx == (IW'(ntap_q) + TAIL));

    assign busy      = (state != ST_IDLE);
    assign clr       = start && (state == ST_IDLE);
    assign fin       = (state == ST_FIN);
    assign samp_rd   = issuing;
    assign coef_rd   = issuing && pre_done;
    assign samp_addr = base_q + AW'(LANES - 1) - AW'(idx);
    assign coef_addr = pre_done ? CAW'(idx - PRELOAD) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            base_q <= '0;
            ntap_q <= '0;
            ret    <= '0;
            done   <= 1'b0;
        end else begin
            done    <= (state == ST_FIN);
            ret.vld <= issuing;
            ret.mac <= issuing && pre_done;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= base_n;
                        ntap_q <= taps;
                        idx    <= '0;
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    idx <= idx + IW'(1);
                    if (last_issue) state <= ST_LAST;
                end
                ST_LAST: state <= ST_FIN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_samp_desc_r2: assert property (@(posedge clk) disable iff (rst)
        samp_rd && $past(samp_rd) |-> samp_addr == $past(samp_addr) - AW'(1));

    p_coef_asc_r3: assert property (@(posedge clk) disable iff (rst)
        coef_rd && $past(coef_rd) |-> coef_addr == $past(coef_addr) + CAW'(1));

    p_coef_paired_r3: assert property (@(posedge clk) disable iff (rst)
        coef_rd |-> samp_rd);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(base_q) && $stable(ntap_q));

endmodule

// File: rtl/msfir_window.sv
module msfir_window
    import msfir_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift_en,
    input  smp_t                      din,
    output logic [LANES-1:0][SW-1:0]  lane_x
);

    // hold[g-1] keeps the sample that lane g-1 used in the previous step
    logic [SW-1:0] hold [LANES-1];

    assign lane_x[0] = din;

    for (genvar g = 1; g < LANES; g++) begin : g_slot
        assign lane_x[g] = hold[g-1];

        always_ff @(posedge clk) begin
            if (rst)           hold[g-1] <= '0;
            else if (shift_en) hold[g-1] <= lane_x[g-1];
        end

        p_slot_hold_r2: assert property (@(posedge clk) disable iff (rst)
            !shift_en |=> $stable(hold[g-1]));
    end

endmodule

// File: rtl/msfir_lane.sv
module msfir_lane
    import msfir_pkg::*;
#(
    parameter int GUARD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic mac_en,
    input  logic fin,
    input  smp_t coef,
    input  smp_t samp,
    output smp_t y
);

    localparam int ACCW = PW + GUARD;

    logic signed [ACCW-1:0] acc;
    logic signed [PW-1:0]   prod;
    logic signed [63:0]     sum_w;
    logic signed [63:0]     sum_c;

    assign prod  = coef * samp;
    assign sum_w = 64'(acc) + 64'(prod);
    assign sum_c = clamp_w(sum_w, ACCW);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            y   <= '0;
        end else begin
            if (clr)         acc <= '0;
            else if (mac_en) acc <= sum_c[ACCW-1:0];
            if (fin)         y   <= round_q15(64'(acc));
        end
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        clr |=> acc == '0);

    p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !clr && !mac_en |=> $stable(acc));

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        !clr && mac_en && !prod[PW-1] |=> acc >= $past(acc));

    p_no_wrap_neg_r5: assert property (@(posedge clk) disable iff (rst)
        !clr && mac_en && prod[PW-1] |=> acc <= $past(acc));

    p_y_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !fin |=> $stable(y));

endmodule

// File: rtl/msfir_engine.sv
module msfir_engine
    import msfir_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int AW       = 12,
    parameter int MAX_TAPS = 64,
    parameter int GUARD    = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic [AW-1:0]                   base_n,
    input  logic [$clog2(MAX_TAPS+1)-1:0]   taps,
    output logic                            busy,
    output logic                            done,
    output logic                            samp_rd,
    output logic [AW-1:0]                   samp_addr,
    input  logic [15:0]                     samp_data,
    output logic                            coef_rd,
    output logic [$clog2(MAX_TAPS)-1:0]     coef_addr,
    input  logic [15:0]                     coef_data,
    output logic [LANES*16-1:0]             y_out
);

    localparam int TW  = $clog2(MAX_TAPS + 1);
    localparam int IW  = $clog2(MAX_TAPS + LANES);
    localparam int CAW = $clog2(MAX_TAPS);

    logic                      clr;
    logic                      fin;
    ret_flags_t                ret;
    logic [LANES-1:0][SW-1:0]  lane_x;

    msfir_seq #(
        .LANES(LANES), .AW(AW), .TW(TW), .IW(IW), .CAW(CAW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base_n    (base_n),
        .taps      (taps),
        .busy      (busy),
        .done      (done),
        .clr       (clr),
        .fin       (fin),
        .samp_rd   (samp_rd),
        .samp_addr (samp_addr),
        .coef_rd   (coef_rd),
        .coef_addr (coef_addr),
        .ret       (ret)
    );

    msfir_window #(.LANES(LANES)) u_win (
        .clk      (clk),
        .rst      (rst),
        .shift_en (ret.vld),
        .din      (smp_t'(samp_data)),
        .lane_x   (lane_x)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        smp_t y_j;

        msfir_lane #(.GUARD(GUARD)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .mac_en (ret.mac),
            .fin    (fin),
            .coef   (smp_t'(coef_data)),
            .samp   (smp_t'(lane_x[j])),
            .y      (y_j)
        );

        assign y_out[j*SW +: SW] = y_j;
    end

    p_done_after_fin_r7: assert property (@(posedge clk) disable iff (rst)
        fin |=> done && !busy);

    p_busy_on_start_r1: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

endmodule

// File: tb/msfir_engine_tb.sv
module msfir_engine_tb;

    localparam int LN   = 4;
    localparam int AWB  = 8;
    localparam int MT   = 32;
    localparam int GD   = 2;
    localparam int ACCW = 32 + GD;
    localparam int TWB  = $clog2(MT + 1);
    localparam int CAWB = $clog2(MT);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [AWB-1:0]  base_n = '0;
    logic [TWB-1:0]  taps = '0;
    logic            busy, done, samp_rd, coef_rd;
    logic [AWB-1:0]  samp_addr;
    logic [CAWB-1:0] coef_addr;
    logic [15:0]     samp_data, coef_data;
    logic [LN*16-1:0] y_out;

    always #10 clk = ~clk;   // 50 MHz

    msfir_engine #(.LANES(LN), .AW(AWB), .MAX_TAPS(MT), .GUARD(GD)) u_dut (
        .clk(clk), .rst(rst), .start(start), .base_n(base_n), .taps(taps),
        .busy(busy), .done(done), .samp_rd(samp_rd), .samp_addr(samp_addr),
        .samp_data(samp_data), .coef_rd(coef_rd), .coef_addr(coef_addr),
        .coef_data(coef_data), .y_out(y_out)
    );

    logic signed [15:0] smem [1 << AWB];
    logic signed [15:0] cmem [MT];

    always @(posedge clk) begin
        samp_data <= smem[samp_addr];
        coef_data <= cmem[coef_addr];
    end

    typedef struct {
        int          n;
        int          nt;
        int          s;
        string       tag;
        logic [63:0] yv;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    int   cur_n = 0;
    int   scnt = 0;
    int   ccnt = 0;
    int   addr_bad = 0;
    logic [63:0] last_y = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint clip(input longint v, input int w);
        longint hi;
        hi = (longint'(1) <<< (w - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    // Serial single-accumulator reference for each lane
    function automatic logic [63:0] model(input int n, input int nt);
        logic [63:0] res;
        res = '0;
        for (int j = 0; j < LN; j++) begin
            longint acc;
            longint r;
            acc = 0;
            for (int k = 0; k < nt; k++) begin
                longint p;
                p   = longint'(cmem[k]) * longint'(smem[(n + j - k) & ((1 << AWB) - 1)]);
                acc = clip(acc + p, ACCW);
            end
            r = clip((acc + 16384) >>> 15, 16);
            res[j*16 +: 16] = r[15:0];
        end
        return res;
    endfunction

    // Monitor: address trace and result scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (samp_rd) begin
                if (int'(samp_addr) != ((cur_n + 3 - scnt) & ((1 << AWB) - 1))) addr_bad++;
                scnt++;
            end
            if (coef_rd) begin
                if (int'(coef_addr) != ccnt) addr_bad++;
                if (scnt < 4) addr_bad++;
                ccnt++;
            end
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc - e.s == e.nt + 6, "R7", "done latency", cyc - e.s, e.nt + 6);
                    for (int j = 0; j < LN; j++) begin
                        logic signed [15:0] a;
                        logic signed [15:0] x;
                        a = y_out[j*16 +: 16];
                        x = e.yv[j*16 +: 16];
                        chk(a == x, e.tag, $sformatf("lane %0d result", j), a, x);
                    end
                    chk(addr_bad == 0, "R2", "sample/coef address order", addr_bad, 0);
                    chk(scnt == e.nt + 3, "R2", "sample read count", scnt, e.nt + 3);
                    chk(ccnt == e.nt, "R3", "coefficient read count", ccnt, e.nt);
                    last_y = e.yv;
                end
                scnt = 0;
                ccnt = 0;
                addr_bad = 0;
            end
        end
    end

    // Driver: push expectation, pulse start, optionally poke start mid-pass
    task automatic run_job(input int n, input int nt, input string tag, input bit poke);
        exp_t e;
        @(negedge clk);
        e.n = n; e.nt = nt; e.s = cyc; e.tag = tag; e.yv = model(n, nt);
        q.push_back(e);
        cur_n  = n;
        start  = 1'b1;
        base_n = AWB'(n);
        taps   = TWB'(nt);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            start  = 1'b1;       // R8: must be ignored
            base_n = AWB'(n + 7);
            taps   = TWB'(3);
            @(negedge clk);
            start = 1'b0;
        end
        wait (q.size() == 0);
        repeat (3) @(negedge clk);
        chk(y_out == last_y, "R7", "outputs hold after done", longint'(y_out[31:0]), longint'(last_y[31:0]));
        chk(busy == 1'b0, "R1", "idle after pass", busy, 0);
    endtask

    task automatic fill_random();
        for (int i = 0; i < (1 << AWB); i++) smem[i] = 16'($urandom);
        for (int i = 0; i < MT; i++) cmem[i] = 16'($urandom);
    endtask

    initial begin
        fill_random();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(y_out == '0, "R1", "y_out after reset", longint'(y_out[31:0]), 0);

        run_job(40, 8, "R4", 1'b0);      // random data, mid-length
        run_job(10, 1, "R4", 1'b0);      // single tap
        run_job(120, MT, "R4", 1'b0);    // full length

        // R5: twelve clipping positives then eight negatives; order matters
        for (int i = 0; i < MT; i++) cmem[i] = (i < 12) ? 16'sd32767 : -16'sd32767;
        for (int i = 30; i < 70; i++) smem[i] = 16'sd32767;
        run_job(60, 20, "R5", 1'b0);
        for (int i = 0; i < MT; i++) cmem[i] = -cmem[i];
        run_job(60, 20, "R5", 1'b0);

        // R6: accumulators 16384, 16383, -16384, -16385 give 1, 0, 0, -1
        cmem[0] = 16'sd1;
        smem[20] = 16'sd16384;
        smem[21] = 16'sd16383;
        smem[22] = -16'sd16384;
        smem[23] = -16'sd16385;
        run_job(20, 1, "R6", 1'b0);
        chk($signed(y_out[15:0]) == 1 && $signed(y_out[63:48]) == -1, "R6",
            "half-up rounding lanes 0 and 3", $signed(y_out[63:48]), -1);

        // R8: start during a pass is ignored
        fill_random();
        run_job(90, 12, "R8", 1'b1);
        run_job(200, 5, "R4", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL all watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule